// File: doc/BRIEF.md
# Freeze-Aware Host Status Register

This block holds the two upper status bits that a host reads from a host/slave FIFO interface. One bit is an output error flag; the other tracks whether the immediate-command-out register has been consumed. The block also holds that command register and drives its contents toward the host data path.

While the interface is frozen, the host sees both status bits forced to 1. Shadow flops keep tracking the real status through the freeze, and the CPU always reads those shadow values. When the freeze is lifted, the host view falls back to the shadow values at once. During a freeze, FIFO underrun detection is turned off. A host read of the command register still returns its contents, and it drives the error flag to 0.

The status pair is presented as a 2-bit field: index 1 is status byte bit 7 (error flag, 1 = no error), and index 0 is status byte bit 6 (command status, 1 = consumed). The FIFO datapath and interrupt logic lie outside this block.

Top module: `host_status_reg`

## Requirements
- R1: After reset, both views read 2'b11 and `cmd_data_o` reads 0.
- R2: A CPU command write loads `cpu_cmd_data_i` into the command register and clears status index 0, both visible from the next cycle.
- R3: A host command read sets status index 0 to 1 on the next cycle. If a CPU command write happens in the same cycle, the write wins and the bit ends up 0.
- R4: Outside freeze, a host FIFO read while `fifo_empty_i` is 1 drives status index 1 to 0 on the next cycle. A FIFO read while the FIFO is not empty leaves the flag unchanged.
- R5: Outside freeze, a host command read while status index 0 is already 1 drives status index 1 to 0 on the next cycle.
- R6: Once status index 1 is 0, it stays 0 until `cpu_err_clr_i`, which sets it to 1 on the next cycle. An error event in the same cycle as the clear wins, so the flag stays 0.
- R7: While `freeze_i` is 1, `host_stat_o` reads 2'b11 in the same cycle, whatever the shadow state.
- R8: During freeze, the shadow bits keep updating as in normal operation, and `cpu_stat_o` always shows the shadow values.
- R9: During freeze, a host FIFO read while the FIFO is empty has no effect on status index 1.
- R10: During freeze, a host command read sees the register contents on `cmd_data_o` and drives status index 1 to 0 on the next cycle.
- R11: While `freeze_i` is 0, `host_stat_o` equals `cpu_stat_o`, including in the first cycle after a freeze is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Interface frozen |
| cpu_cmd_wr_i | input | 1 | CPU write strobe for the command register |
| cpu_cmd_data_i | input | DATA_W | CPU write data for the command register |
| cpu_err_clr_i | input | 1 | CPU strobe that restores the error flag to 1 |
| host_cmd_rd_i | input | 1 | Host read strobe of the command register |
| host_fifo_rd_i | input | 1 | Host read strobe of the output FIFO |
| fifo_empty_i | input | 1 | Output FIFO is empty |
| host_stat_o | output | 2 | Host view: [1] error flag, [0] command status |
| cpu_stat_o | output | 2 | CPU view (shadow values), same layout |
| cmd_data_o | output | DATA_W | Command register contents |

## Verification
The bench targets four groups of cases.

- **Same-cycle conflicts.** It drives a CPU write together with a host read, and an error event together with a CPU clear. A design with the wrong priority leaves the command bit at 1 or clears a real error.
- **Shadow tracking under freeze.** It writes and reads the command register while frozen, then checks the CPU view and the first cycle after release. A design that freezes its shadows, or restores late, shows stale status on resume.
- **Underrun detection mode.** Empty-FIFO reads during freeze must be ignored, yet a command read during freeze must still drive the error flag low. A design that conflates the two paths fails one of these checks.
- **Random traffic.** Seeded random traffic compares every output against a bench model on every cycle.

// File: rtl/host_status_pkg.sv
package host_status_pkg;
  localparam int unsigned STAT_W   = 2;
  localparam int unsigned ERR_IDX  = 1;  // status byte bit 7
  localparam int unsigned CMD_IDX  = 0;  // status byte bit 6
  localparam logic [STAT_W-1:0] FROZEN_VIEW = '1;
endpackage

// File: rtl/hs_err_flag.sv
module hs_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic host_cmd_rd_i,
  input  logic host_fifo_rd_i,
  input  logic fifo_empty_i,
  input  logic cmd_free_i,
  input  logic cpu_err_clr_i,
  output logic err_ok_o
);
  logic err_ok_q;
  logic underrun, cmd_overread, frz_cmd_rd, err_evt;

  // underrun detection is off while frozen
  assign underrun     = !freeze_i && host_fifo_rd_i && fifo_empty_i;
  assign cmd_overread = !freeze_i && host_cmd_rd_i && cmd_free_i;
  assign frz_cmd_rd   = freeze_i && host_cmd_rd_i;
  assign err_evt      = underrun || cmd_overread || frz_cmd_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            err_ok_q <= 1'b1;
    else if (err_evt)       err_ok_q <= 1'b0;
    else if (cpu_err_clr_i) err_ok_q <= 1'b1;
  end

  assign err_ok_o = err_ok_q;

  assert_underrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && host_fifo_rd_i && fifo_empty_i) |=> !err_ok_o);
  assert_overread_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && host_cmd_rd_i && cmd_free_i) |=> !err_ok_o);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_ok_o && !cpu_err_clr_i) |=> !err_ok_o);
  assert_frozen_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !host_cmd_rd_i && !cpu_err_clr_i) |=> $stable(err_ok_o));
  assert_frozen_cmd_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && host_cmd_rd_i) |=> !err_ok_o);
endmodule

// File: rtl/hs_cmd_track.sv
module hs_cmd_track #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_cmd_wr_i,
  input  logic [DATA_W-1:0] cpu_cmd_data_i,
  input  logic              host_cmd_rd_i,
  output logic              cmd_free_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic              free_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= 1'b1;
      data_q <= '0;
    end else begin
      if (cpu_cmd_wr_i) begin
        free_q <= 1'b0;  // new command wins over a same-cycle read
        data_q <= cpu_cmd_data_i;
      end else if (host_cmd_rd_i) begin
        free_q <= 1'b1;
      end
    end
  end

  assign cmd_free_o = free_q;
  assign cmd_data_o = data_q;

  assert_wr_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_cmd_wr_i |=> (!cmd_free_o && cmd_data_o == $past(cpu_cmd_data_i)));
  assert_rd_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_cmd_rd_i && !cpu_cmd_wr_i) |=> cmd_free_o);
  assert_data_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_cmd_wr_i |=> $stable(cmd_data_o));
endmodule

// File: rtl/host_status_reg.sv
module host_status_reg
  import host_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic              cpu_cmd_wr_i,
  input  logic [DATA_W-1:0] cpu_cmd_data_i,
  input  logic              cpu_err_clr_i,
  input  logic              host_cmd_rd_i,
  input  logic              host_fifo_rd_i,
  input  logic              fifo_empty_i,
  output logic [1:0]        host_stat_o,
  output logic [1:0]        cpu_stat_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic cmd_free, err_ok;
  logic [STAT_W-1:0] shadow;

  hs_cmd_track #(.DATA_W(DATA_W)) u_cmd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpu_cmd_wr_i   (cpu_cmd_wr_i),
    .cpu_cmd_data_i (cpu_cmd_data_i),
    .host_cmd_rd_i  (host_cmd_rd_i),
    .cmd_free_o     (cmd_free),
    .cmd_data_o     (cmd_data_o)
  );

  hs_err_flag u_err (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .freeze_i       (freeze_i),
    .host_cmd_rd_i  (host_cmd_rd_i),
    .host_fifo_rd_i (host_fifo_rd_i),
    .fifo_empty_i   (fifo_empty_i),
    .cmd_free_i     (cmd_free),
    .cpu_err_clr_i  (cpu_err_clr_i),
    .err_ok_o       (err_ok)
  );

  always_comb begin
    shadow          = '0;
    shadow[ERR_IDX] = err_ok;
    shadow[CMD_IDX] = cmd_free;
  end

  assign cpu_stat_o  = shadow;
  assign host_stat_o = freeze_i ? FROZEN_VIEW : shadow;

  assert_shadow_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && cpu_cmd_wr_i) |=> !cpu_stat_o[CMD_IDX]);
  assert_resume_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(freeze_i) |-> (host_stat_o[CMD_IDX] == cmd_free && host_stat_o[ERR_IDX] == err_ok));
  assert_frozen_view_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |-> $countones(host_stat_o) == STAT_W);
endmodule

// File: tb/tb_host_status_reg.sv
module tb_host_status_reg;
  localparam int unsigned DATA_W = 8;
  localparam time T = 20ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic freeze, wr, clr, hrd, frd, emp;
  logic [DATA_W-1:0] wdata;
  logic [1:0] host_stat, cpu_stat;
  logic [DATA_W-1:0] cmd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_err, m_free;
  logic [DATA_W-1:0] m_data;

  always #(T/2) clk = ~clk;

  host_status_reg #(.DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .freeze_i(freeze),
    .cpu_cmd_wr_i(wr), .cpu_cmd_data_i(wdata), .cpu_err_clr_i(clr),
    .host_cmd_rd_i(hrd), .host_fifo_rd_i(frd), .fifo_empty_i(emp),
    .host_stat_o(host_stat), .cpu_stat_o(cpu_stat), .cmd_data_o(cmd_data)
  );

  function automatic logic nx_err(logic e, logic f, logic fr, logic rd, logic fifo_rd,
                                  logic empty, logic cl);
    logic evt;
    evt = (!fr && fifo_rd && empty) || (!fr && rd && f) || (fr && rd);
    if (evt) return 1'b0;
    if (cl) return 1'b1;
    return e;
  endfunction

  function automatic logic nx_free(logic f, logic w, logic rd);
    if (w) return 1'b0;
    if (rd) return 1'b1;
    return f;
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [1:0] sh;
    sh = {m_err, m_free};
    chk({tag, " cpu_stat"}, DATA_W'(cpu_stat), DATA_W'(sh));
    chk({tag, " host_stat"}, DATA_W'(host_stat), DATA_W'(freeze ? 2'b11 : sh));
    chk({tag, " cmd_data"}, cmd_data, m_data);
  endtask

  task automatic step(string tag, logic fr, logic w, logic [DATA_W-1:0] d, logic rd,
                      logic fifo_rd, logic empty, logic cl);
    @(negedge clk);
    freeze = fr; wr = w; wdata = d; hrd = rd; frd = fifo_rd; emp = empty; clr = cl;
    @(posedge clk);
    m_err  = nx_err(m_err, m_free, fr, rd, fifo_rd, empty, cl);
    m_free = nx_free(m_free, w, rd);
    if (w) m_data = d;
    #2;
    // drop strobes before the check so host view reflects the held freeze level only
    wr = 0; hrd = 0; frd = 0; clr = 0;
    #3;
    check_all(tag);
  endtask

  initial begin
    #(T * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    freeze = 0; wr = 0; wdata = '0; clr = 0; hrd = 0; frd = 0; emp = 0;
    m_err = 1; m_free = 1; m_data = '0;
    #(T*3);
    check_all("R1 reset");
    @(negedge clk) rst_ni = 1'b1;
    #1 check_all("R1 after release");

    step("R2 cpu write",            0, 1, 8'hA5, 0, 0, 0, 0);
    step("R3 host read sets",       0, 0, 8'h00, 1, 0, 0, 0);
    step("R5 overread",             0, 0, 8'h00, 1, 0, 0, 0);
    step("R6 sticky",               0, 0, 8'h00, 0, 0, 1, 0);
    step("R6 clear",                0, 0, 8'h00, 0, 0, 0, 1);
    step("R4 read nonempty",        0, 0, 8'h00, 0, 1, 0, 0);
    step("R4 underrun",             0, 0, 8'h00, 0, 1, 1, 0);
    step("R6 error beats clear",    0, 0, 8'h00, 0, 1, 1, 1);
    step("R6 clear again",          0, 0, 8'h00, 0, 0, 0, 1);
    step("R3 write wins",           0, 1, 8'h5A, 1, 0, 0, 0);
    step("R7 R8 frozen write",      1, 1, 8'h3C, 0, 0, 0, 0);
    step("R9 frozen underrun",      1, 0, 8'h00, 0, 1, 1, 0);
    step("R10 frozen cmd read",     1, 0, 8'h00, 1, 0, 0, 0);
    step("R8 frozen clear",         1, 0, 8'h00, 0, 0, 0, 1);
    step("R8 frozen write",         1, 1, 8'h77, 0, 0, 0, 0);
    step("R11 release",             0, 0, 8'h00, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic fr;
      fr = ($urandom % 4) == 0;
      step(fr ? "R8 random frozen" : "R11 random normal", fr,
           ($urandom % 5) == 0, DATA_W'($urandom), ($urandom % 5) == 0,
           ($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 6) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule